// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block runs a 16-bit successive-approximation converter with a parallel output from the host side. Each conversion uses a chip-select line and a read/convert level. The sequencer makes three chip-select falling edges per conversion. The first, with read/convert low, wakes the converter and opens the sampling window. The second ends sampling and starts conversion, and its read/convert level tells the converter to keep or drop its reference afterwards. The third, with read/convert high, brings the result onto the bus once the converter has pulled its end-of-conversion line low.

The sequencer counts every analog timing limit in clock cycles. Each limit is given in nanoseconds and rounded up using the clock-frequency parameter. When the previous conversion powered the reference down, or after any converter reset, the sampling window stretches to the reference wake-up time. If end-of-conversion never falls, a timeout flag is raised and the converter is reset.

The user side has a start request, a power-down select, the captured sample and a one-cycle valid strobe.

Top module: `sar_host_seq`

## Requirements
- R1: Converter reset and first conversion.
  - While the block is in reset, and for at least two cycles after reset is released, the converter reset output is high with chip-select high.
  - Throughout that time the valid and timeout outputs are 0.
  - The first conversion after any converter reset uses the long wake-up sampling window.
- R2: A start request starts a conversion only when the sequencer is idle. A request made while a conversion is in flight has no effect: exactly three chip-select falling edges are made per accepted start.
- R3: The first falling edge of each conversion (acquire) is made with read/convert at 0.
- R4: The second falling edge (convert) is made with read/convert equal to the power-down select sampled with the accepted start. 1 means drop the reference after conversion; 0 means keep it on.
- R5: Sampling window length, measured from the first to the second falling edge.
  - The window is at least the acquisition time, rounded up to whole cycles.
  - After a conversion that chose power-down, or after a converter reset, the window is at least the wake-up time.
  - Otherwise the window is exactly two cycles plus the rounded-up acquisition time minus two cycles. With the defaults at 50 MHz this is 100 cycles.
- R6: The third falling edge (read) is made with read/convert at 1. It comes only after end-of-conversion has been seen high and then low following the convert edge.
- R7: Result capture.
  - The sample output takes the bus value present at least output-valid-delay plus one cycles after the read edge.
  - The valid output pulses for exactly one cycle per completed conversion.
- R8: Pulse widths and read/convert stability.
  - Every chip-select low pulse lasts at least max(ceil(pulse width), 2) cycles, and so does every high pulse.
  - Read/convert never changes while chip-select stays low.
  - Read/convert is steady in the cycle before each falling edge.
- R9: After the read pulse ends, chip-select stays high for at least the bus-release time before the next acquire edge.
- R10: Conversion timeout.
  - If end-of-conversion has not fallen twice the maximum conversion time after the convert edge, the timeout output goes to 1 and no valid is given.
  - The converter reset is then pulsed, and the next conversion uses the wake-up window.
  - The flag clears when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, acted on only while idle |
| shutdown_i | input | 1 | 1: drop the reference after this conversion; 0: keep it on |
| adc_eoc_i | input | 1 | End-of-conversion from the converter; low means done |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rc_o | output | 1 | Read/convert level |
| adc_reset_o | output | 1 | Converter reset, active high |
| sample_o | output | DATA_W | Last captured conversion result |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| eoc_timeout_o | output | 1 | End-of-conversion timeout flag |

## Verification
A behavioural converter model answers every edge, and each expected word is queued before its conversion.

Conversions alternate between keep-reference and drop-reference choices. This shows whether the long window follows a power-down or a reset, and is skipped after a standby conversion. End-of-conversion delays range from one cycle to near the maximum, which checks the high-then-low arming rule. A conversion whose end-of-conversion never falls checks the timeout, the converter reset and the recovery. A second start pulsed during a conversion must add no edges.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_RST,
    ST_GAP,
    ST_IDLE,
    ST_ACQ_LO,
    ST_ACQ_HI,
    ST_CNV_LO,
    ST_CNV_HI,
    ST_RD_LO
  } seq_state_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned hz);
    longint unsigned prod;
    prod = ns * hz;
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int unsigned at_least(input int unsigned a,
                                           input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sub_floor(input int unsigned a,
                                            input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic ff1_q;
  logic ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;

endmodule

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R5: an expired count stays expired until reloaded
  a_r5_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);

endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned T_ACQ_NS  = 2000,
  parameter int unsigned T_CONV_NS = 4700,
  parameter int unsigned T_PW_NS   = 40,
  parameter int unsigned T_DO_NS   = 40,
  parameter int unsigned T_BR_NS   = 60,
  parameter int unsigned T_WAKE_NS = 12_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              shutdown_i,
  input  logic              adc_eoc_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_cs_n_o,
  output logic              adc_rc_o,
  output logic              adc_reset_o,
  output logic [DATA_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic              eoc_timeout_o
);

  localparam int unsigned PW_C    = at_least(ns_to_cyc(T_PW_NS, CLK_HZ), 2);
  localparam int unsigned ACQ_C   = ns_to_cyc(T_ACQ_NS, CLK_HZ);
  localparam int unsigned WAKE_C  = ns_to_cyc(T_WAKE_NS, CLK_HZ);
  localparam int unsigned DO_C    = ns_to_cyc(T_DO_NS, CLK_HZ);
  localparam int unsigned BR_C    = ns_to_cyc(T_BR_NS, CLK_HZ);
  localparam int unsigned CONV_C  = ns_to_cyc(T_CONV_NS, CLK_HZ);
  localparam int unsigned AHI_C   = at_least(sub_floor(ACQ_C, PW_C), PW_C);
  localparam int unsigned WHI_C   = at_least(sub_floor(at_least(WAKE_C, ACQ_C), PW_C), PW_C);
  localparam int unsigned RD_C    = at_least(PW_C, DO_C + 1);
  localparam int unsigned GAP_C   = at_least(BR_C, PW_C);
  localparam int unsigned TO_C    = at_least(2 * CONV_C, PW_C + 1);
  localparam int unsigned MAX_C   = at_least(at_least(WHI_C, TO_C), at_least(RD_C, GAP_C));
  localparam int unsigned CNT_W   = $clog2(MAX_C + 1);

  logic              rst_sn;
  logic              eoc_s;
  seq_state_e        state_q, state_d;
  logic              mode_q, mode_d;
  logic              wake_q, wake_d;
  logic              seen_q, seen_d;
  logic              cs_n_q, cs_n_d;
  logic              rc_q, rc_d;
  logic              rstp_q, rstp_d;
  logic              vld_q, vld_d;
  logic              tmo_q, tmo_d;
  logic [DATA_W-1:0] smp_q;
  logic              mode_en;
  logic              t1_ld, t1_done, t2_ld, t2_done;
  logic [CNT_W-1:0]  t1_val;

  sar_seq_sync #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sn));

  sar_seq_sync #(.RST_VAL(1'b0)) u_eoc_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(adc_eoc_i), .q_o(eoc_s));

  sar_seq_timer #(.W(CNT_W), .INIT(CNT_W'(PW_C - 1))) u_phase_tmr (
    .clk(clk), .rst_n(rst_sn), .load_i(t1_ld), .val_i(t1_val), .done_o(t1_done));

  sar_seq_timer #(.W(CNT_W), .INIT('0)) u_conv_tmr (
    .clk(clk), .rst_n(rst_sn), .load_i(t2_ld), .val_i(CNT_W'(TO_C - 1)),
    .done_o(t2_done));

  // next state
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    wake_d  = wake_q;
    seen_d  = seen_q;
    tmo_d   = tmo_q;
    vld_d   = 1'b0;
    mode_en = 1'b0;
    case (state_q)
      ST_RST: begin
        wake_d = 1'b1;
        if (t1_done) state_d = ST_GAP;
      end
      ST_GAP:    if (t1_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ACQ_LO;
          mode_d  = shutdown_i;
          mode_en = 1'b1;
          tmo_d   = 1'b0;
          seen_d  = 1'b0;
        end
      end
      ST_ACQ_LO: if (t1_done) state_d = ST_ACQ_HI;
      ST_ACQ_HI: if (t1_done) state_d = ST_CNV_LO;
      ST_CNV_LO: begin
        if (eoc_s) seen_d = 1'b1;
        if (t1_done) state_d = ST_CNV_HI;
      end
      ST_CNV_HI: begin
        if (eoc_s) seen_d = 1'b1;
        if (t2_done) begin
          state_d = ST_RST;
          tmo_d   = 1'b1;
        end else if (t1_done && seen_q && !eoc_s) begin
          state_d = ST_RD_LO;
        end
      end
      ST_RD_LO: begin
        if (t1_done) begin
          state_d = ST_GAP;
          vld_d   = 1'b1;
          wake_d  = mode_q;
        end
      end
      default: state_d = ST_RST;
    endcase
  end

  // pin levels and phase lengths follow the next state
  always_comb begin
    cs_n_d = !(state_d inside {ST_ACQ_LO, ST_CNV_LO, ST_RD_LO});
    rstp_d = (state_d == ST_RST);
    case (state_d)
      ST_ACQ_HI, ST_CNV_LO: rc_d = mode_d;
      ST_CNV_HI, ST_RD_LO:  rc_d = 1'b1;
      default:              rc_d = 1'b0;
    endcase
    case (state_d)
      ST_RST:    t1_val = CNT_W'(PW_C - 1);
      ST_GAP:    t1_val = CNT_W'(GAP_C - 1);
      ST_ACQ_LO: t1_val = CNT_W'(PW_C - 1);
      ST_ACQ_HI: t1_val = wake_q ? CNT_W'(WHI_C - 1) : CNT_W'(AHI_C - 1);
      ST_CNV_LO: t1_val = CNT_W'(PW_C - 1);
      ST_CNV_HI: t1_val = CNT_W'(PW_C - 1);
      ST_RD_LO:  t1_val = CNT_W'(RD_C - 1);
      default:   t1_val = '0;
    endcase
    t1_ld = (state_d != state_q);
    t2_ld = (state_d == ST_CNV_LO) && (state_q != ST_CNV_LO);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_RST;
      wake_q  <= 1'b1;
      seen_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      rc_q    <= 1'b0;
      rstp_q  <= 1'b1;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      seen_q  <= seen_d;
      cs_n_q  <= cs_n_d;
      rc_q    <= rc_d;
      rstp_q  <= rstp_d;
      vld_q   <= vld_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    smp_q <= '0;
    else if (vld_d) smp_q <= adc_data_i;
  end

  assign adc_cs_n_o     = cs_n_q;
  assign adc_rc_o       = rc_q;
  assign adc_reset_o    = rstp_q;
  assign sample_o       = smp_q;
  assign sample_valid_o = vld_q;
  assign eoc_timeout_o  = tmo_q;

  a_r8_rc_steady_at_fall: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(adc_cs_n_o) |-> $stable(adc_rc_o));

  a_r8_rc_frozen_low: assert property (@(posedge clk) disable iff (!rst_sn)
    (!adc_cs_n_o && $past(!adc_cs_n_o)) |-> $stable(adc_rc_o));

  a_r8_low_width: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(adc_cs_n_o) |-> !$past(adc_cs_n_o, 2));

  a_r8_high_width: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(adc_cs_n_o) |-> $past(adc_cs_n_o, 2));

  a_r1_reset_cs_high: assert property (@(posedge clk) disable iff (!rst_sn)
    adc_reset_o |-> adc_cs_n_o);

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_sn)
    sample_valid_o |=> !sample_valid_o);

  a_r10_no_valid_on_timeout: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(eoc_timeout_o) |-> !sample_valid_o);

  a_r6_read_edge_rc_high: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(adc_cs_n_o) && $past(state_q == ST_CNV_HI)) |-> adc_rc_o);

endmodule

// File: tb/sar_host_seq_test.sv
module sar_host_seq_test;

  localparam int ACQ_C  = 100;   // 2000 ns at 50 MHz
  localparam int WAKE_C = 300;   // 6000 ns at 50 MHz
  localparam int TO_C   = 470;   // 2 x 4700 ns
  localparam int PW_C   = 2;
  localparam int BR_C   = 3;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        shutdown;
  logic        eoc;
  logic [15:0] adc_data;
  logic        cs_n, rc, adc_rst;
  logic [15:0] sample;
  logic        valid, tmo;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sar_host_seq #(.CLK_HZ(50_000_000), .T_WAKE_NS(6000)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(shutdown),
    .adc_eoc_i(eoc), .adc_data_i(adc_data), .adc_cs_n_o(cs_n), .adc_rc_o(rc),
    .adc_reset_o(adc_rst), .sample_o(sample), .sample_valid_o(valid),
    .eoc_timeout_o(tmo));

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // converter model state
  logic [15:0] model_word;
  logic [15:0] expq[$];
  bit  reading, hang, exp_mode, exp_wake, eoc_fell, saw_rst;
  bit  prev_cs, prev_rc, prev_valid, prev_tmo;
  int  cyc, edge_n, t_first, t_conv, t_rise, t_fall, conv_cnt, conv_delay, falls;

  assign adc_data = reading ? model_word : ~model_word;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      edge_n = 0; eoc = 1'b0; conv_cnt = 0; reading = 1'b0;
      prev_cs = 1'b1; prev_rc = 1'b0; prev_valid = 1'b0; prev_tmo = 1'b0;
      t_rise = cyc; t_fall = cyc;
    end else begin
      if (adc_rst) begin
        edge_n = 0; eoc = 1'b0; conv_cnt = 0; reading = 1'b0; saw_rst = 1'b1;
      end
      if (conv_cnt > 0) begin
        conv_cnt--;
        if (conv_cnt == 0) begin eoc = 1'b0; eoc_fell = 1'b1; end
      end
      if (prev_cs && !cs_n) begin
        falls++;
        chk(cyc - t_rise >= PW_C, "R8", "cs high width", cyc - t_rise, PW_C);
        t_fall = cyc;
        case (edge_n)
          0: begin
            chk(rc == 1'b0, "R3", "rc at acquire edge", rc, 0);
            chk(cyc - t_rise >= BR_C, "R9", "bus release gap", cyc - t_rise, BR_C);
            t_first = cyc; edge_n = 1;
          end
          1: begin
            chk(rc == exp_mode, "R4", "rc at convert edge", rc, exp_mode);
            chk(cyc - t_first >= ACQ_C, "R5", "acquire window", cyc - t_first, ACQ_C);
            if (exp_wake)
              chk(cyc - t_first >= WAKE_C, "R5", "wake window", cyc - t_first, WAKE_C);
            else
              chk(cyc - t_first == ACQ_C, "R5", "standby window", cyc - t_first, ACQ_C);
            t_conv = cyc; eoc = 1'b1; eoc_fell = 1'b0;
            conv_cnt = hang ? 0 : conv_delay;
            edge_n = 2;
          end
          2: begin
            chk(rc == 1'b1, "R6", "rc at read edge", rc, 1);
            chk(eoc_fell && !eoc, "R6", "read before eoc fell", eoc_fell, 1);
            reading = 1'b1; edge_n = 3;
          end
          default: chk(1'b0, "R2", "extra falling edge", edge_n, 0);
        endcase
      end
      if (!prev_cs && cs_n) begin
        chk(cyc - t_fall >= PW_C, "R8", "cs low width", cyc - t_fall, PW_C);
        t_rise = cyc; reading = 1'b0;
        if (edge_n == 3) edge_n = 0;
      end
      if (!cs_n && !prev_cs && rc != prev_rc)
        chk(1'b0, "R8", "rc moved while cs low", rc, prev_rc);
      if (tmo && !prev_tmo) begin
        chk(cyc - t_conv >= TO_C, "R10", "timeout delay", cyc - t_conv, TO_C);
        chk(!valid, "R10", "valid with timeout", valid, 0);
      end
      if (valid) begin
        if (prev_valid) chk(1'b0, "R7", "valid longer than one cycle", 2, 1);
        if (expq.size() == 0) chk(1'b0, "R7", "unexpected sample", sample, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(sample == e, "R7", "sample value", sample, e);
        end
      end
      prev_cs = cs_n; prev_rc = rc; prev_valid = valid; prev_tmo = tmo;
    end
  end

  int exp_falls = 0;

  task automatic run_conv(input bit mode, input logic [15:0] word, input int delay,
                          input bit hang_i, input bit extra_start);
    exp_mode = mode; model_word = word; conv_delay = delay; hang = hang_i;
    if (!hang_i) expq.push_back(word);
    @(negedge clk); start = 1'b1; shutdown = mode;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!tmo, "R10", "flag cleared on start", tmo, 0);
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1; shutdown = ~mode;
      @(negedge clk); start = 1'b0;
    end
    for (int n = 0; n < 5000 && !(valid || tmo); n++) @(negedge clk);
    if (hang_i) begin
      chk(tmo, "R10", "timeout flag", tmo, 1);
      exp_wake = 1'b1;
      exp_falls += 2;
    end else begin
      chk(valid, "R7", "completion strobe", valid, 1);
      exp_wake = mode;
      exp_falls += 3;
    end
    repeat (40) @(negedge clk);
    chk(falls == exp_falls, "R2", "edges per accepted start", falls, exp_falls);
    if (hang_i) begin
      chk(saw_rst, "R10", "converter reset after timeout", saw_rst, 1);
      chk(tmo, "R10", "flag held until next start", tmo, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 1'b0; start = 1'b0; shutdown = 1'b0; model_word = '0;
    hang = 1'b0; exp_wake = 1'b1; saw_rst = 1'b0; conv_delay = 100;
    repeat (5) @(negedge clk);
    chk(cs_n, "R1", "cs in reset", cs_n, 1);
    chk(adc_rst, "R1", "converter reset in reset", adc_rst, 1);
    chk(!valid && !tmo, "R1", "flags in reset", valid | tmo, 0);
    rst_n = 1'b1;
    hi = 0;
    while (adc_rst && hi < 100) begin
      chk(cs_n, "R1", "cs during reset pulse", cs_n, 1);
      @(negedge clk); hi++;
    end
    chk(hi >= PW_C, "R1", "reset pulse length", hi, PW_C);
    repeat (10) @(negedge clk);
    saw_rst = 1'b0;

    run_conv(1'b0, 16'h0000, 150, 1'b0, 1'b0);  // R1 wake window after reset
    run_conv(1'b0, 16'hFFFF, 150, 1'b0, 1'b0);  // standby, exact window
    run_conv(1'b1, 16'h8000, 200, 1'b0, 1'b0);  // power-down chosen
    run_conv(1'b0, 16'h7FFF, 1,   1'b0, 1'b0);  // wake after power-down, fast eoc
    run_conv(1'b0, 16'h1234, 150, 1'b0, 1'b1);  // R2 start while busy
    run_conv(1'b0, 16'hDEAD, 0,   1'b1, 1'b0);  // R10 hang
    saw_rst = 1'b0;
    run_conv(1'b0, 16'hA55A, 235, 1'b0, 1'b0);  // wake after timeout
    run_conv(1'b1, 16'h0001, 100, 1'b0, 1'b0);
    run_conv(1'b1, 16'h5A5A, 100, 1'b0, 1'b0);  // wake again
    chk(expq.size() == 0, "R7", "samples outstanding", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule